// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that software must service within a time window. A down-counter, up to 12 bits wide, loses one count on each pulse of an external 256 Hz tick. Software keeps the system alive by writing a keyed restart command, which reloads the counter. The command is legal only once the counter has fallen to or below a programmed window threshold. A restart that comes too early is a fault, and so is letting the counter run out.

Software sets the configuration in a single write to a mode register; the block accepts no later change until reset. A fault sets a sticky status bit. Depending on the mode, it also raises an interrupt that stays high until software reads status, and sends a one-cycle reset request that can be marked as processor-only. The counter can pause while the system is idle or halted for debug, each only when enabled in the mode. A disable bit stops the watchdog altogether. Software reaches the three registers over a simple single-cycle bus. Read data is combinational from the word address.

Top module: `wwdt_top`

## Requirements
- R1: After reset the mode register reads 0x3FFF2FFF (reload 0xFFF, threshold 0xFFF, reset enable and both halt enables set), the status register reads 0, and fault_irq, rst_req and rst_proc_only are low.
- R2: The counter drops by one on each tick. A tick that arrives while the counter is 0 is an underflow: it sets status bit 0 and reloads the counter with the reload value. With the reset configuration the underflow comes on the 4096th tick.
- R3: The mode register is at word address 1 and accepts only the first write after reset. Later writes have no effect. The accepted write also loads the counter with its new reload value. Layout: [11:0] reload, [12] interrupt enable, [13] reset enable, [14] processor-only, [15] disable, [27:16] window threshold, [28] debug-halt enable, [29] idle-halt enable. Bits [31:30] read as 0.
- R4: A write to the control register (word address 0) with 0xA5 in bits [31:24] and bit 0 set is a restart. When the counter is at or below the threshold, the restart reloads the counter and raises no fault.
- R5: The same restart issued while the counter is above the threshold sets status bit 1. The counter is not reloaded and keeps counting.
- R6: A control write with any other key, or with bit 0 clear, has no effect.
- R7: The status register is at word address 2 and reads underflow in bit 0 and error in bit 1. A read clears both bits; a fault in the same cycle as the read still sets its bit.
- R8: fault_irq rises in the cycle after a fault when the interrupt enable is set, and stays high until status is read. It never rises while the interrupt enable is clear.
- R9: Each fault gives a one-cycle pulse on rst_req when the reset enable is set. rst_proc_only pulses together with it when the processor-only bit is set.
- R10: With the disable bit set the counter holds, restarts and ticks cause no fault, and the outputs stay low. Only a reset undoes this.
- R11: The counter holds while idle_halt is high and the idle-halt enable is set, and likewise for debug_halt with its enable. A halt input whose enable is clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle count enable at 256 Hz |
| idle_halt | input | 1 | System idle indication |
| debug_halt | input | 1 | Debugger halt indication |
| req_valid | input | 1 | Bus access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Word address: 0 control, 1 mode, 2 status |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data for req_addr, combinational |
| fault_irq | output | 1 | Fault interrupt, held until status read |
| rst_req | output | 1 | One-cycle reset request per fault |
| rst_proc_only | output | 1 | Marks the reset request as processor-only |

## Verification
The main stimulus is a sweep of the restart point over every counter value from the reload value down to 0, with a threshold of 10. This separates legal restarts from early ones, exactly at the threshold and one count above it. Wrong-key and missing-bit commands are issued just before an expected underflow and above the threshold, so any accepted command would show up as a missing underflow or a spurious error. Each halt source is held for more ticks than the reload value, with its enable set and with it clear, and the tick count to the next underflow shows whether counting paused. Separate resets cover the default configuration, disabled mode and processor-only reset routing.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

   localparam int MODE_W   = 30;
   localparam int FIELD_W  = 12;
   localparam int KEY_LSB  = 24;

   typedef enum logic [1:0] {
      A_CTRL = 2'd0,
      A_MODE = 2'd1,
      A_STAT = 2'd2
   } reg_addr_e;

   typedef struct packed {
      logic               idle_en;
      logic               dbg_en;
      logic [FIELD_W-1:0] window;
      logic               dis;
      logic               proc_only;
      logic               rst_en;
      logic               irq_en;
      logic [FIELD_W-1:0] reload;
   } mode_t;

   localparam logic [MODE_W-1:0] MODE_RST = 30'h3FFF_2FFF;

endpackage

// File: rtl/wwdt_regs.sv
module wwdt_regs
   import wwdt_pkg::*;
#(
   parameter int         DATA_W = 32,
   parameter logic [7:0] KEY    = 8'hA5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        status,
   output mode_t             mode_q,
   output logic              locked,
   output logic              mode_wr,
   output logic              restart,
   output logic              stat_rd,
   output logic [DATA_W-1:0] rdata
);

   localparam int PAD_W = DATA_W - MODE_W;

   logic wr_ctrl;

   assign wr_ctrl = req_valid && req_write && (req_addr == A_CTRL);
   assign restart = wr_ctrl && (req_wdata[KEY_LSB +: 8] == KEY) && req_wdata[0];
   assign mode_wr = req_valid && req_write && (req_addr == A_MODE) && !locked;
   assign stat_rd = req_valid && !req_write && (req_addr == A_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= mode_t'(MODE_RST);
         locked <= 1'b0;
      end else if (mode_wr) begin
         mode_q <= mode_t'(req_wdata[MODE_W-1:0]);
         locked <= 1'b1;
      end
   end

   always_comb begin
      rdata = '0;
      unique case (req_addr)
         A_MODE:  rdata = {{PAD_W{1'b0}}, mode_q};
         A_STAT:  rdata = {{(DATA_W-2){1'b0}}, status};
         default: rdata = '0;
      endcase
   end

endmodule

// File: rtl/wwdt_counter.sv
module wwdt_counter #(
   parameter int CNT_W  = 12,
   parameter int N_HALT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              run_en,
   input  logic [N_HALT-1:0] halt_req,
   input  logic [N_HALT-1:0] halt_en,
   input  logic [CNT_W-1:0]  reload,
   input  logic [CNT_W-1:0]  window,
   input  logic              load,
   input  logic [CNT_W-1:0]  load_val,
   input  logic              restart,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              uf_evt,
   output logic              err_evt
);

   logic [N_HALT-1:0] held;
   logic              paused;
   logic              step;
   logic              in_window;
   logic              good_rst;

   for (genvar i = 0; i < N_HALT; i++) begin : g_halt
      assign held[i] = halt_req[i] & halt_en[i];
   end

   assign paused    = |held;
   assign in_window = (cnt_q <= window);
   assign good_rst  = run_en && restart && in_window;
   assign step      = run_en && tick && !paused && !load;
   assign uf_evt    = step && !good_rst && (cnt_q == '0);
   assign err_evt   = run_en && restart && !in_window && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '1;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (good_rst) begin
         cnt_q <= reload;
      end else if (step) begin
         cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/wwdt_fault.sv
module wwdt_fault (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       uf_evt,
   input  logic       err_evt,
   input  logic       stat_rd,
   input  logic       irq_en,
   input  logic       rst_en,
   input  logic       proc_only,
   output logic [1:0] status,
   output logic       irq,
   output logic       rst_pulse,
   output logic       rst_proc
);

   logic any_fault;

   assign any_fault = uf_evt | err_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status    <= 2'b00;
         irq       <= 1'b0;
         rst_pulse <= 1'b0;
         rst_proc  <= 1'b0;
      end else begin
         status    <= (stat_rd ? 2'b00 : status) | {err_evt, uf_evt};
         irq       <= (irq && !stat_rd) || (irq_en && any_fault);
         rst_pulse <= rst_en && any_fault;
         rst_proc  <= rst_en && proc_only && any_fault;
      end
   end

endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
   import wwdt_pkg::*;
#(
   parameter int         CNT_W  = 12,
   parameter int         DATA_W = 32,
   parameter logic [7:0] KEY    = 8'hA5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              idle_halt,
   input  logic              debug_halt,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              fault_irq,
   output logic              rst_req,
   output logic              rst_proc_only
);

   localparam int N_HALT = 2;

   if (CNT_W < 4 || CNT_W > FIELD_W) begin : g_bad_cnt
      $error("wwdt_top: CNT_W must lie in 4..12");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("wwdt_top: DATA_W must be 32");
   end

   mode_t            mode_q;
   logic             locked;
   logic             mode_wr;
   logic             restart;
   logic             stat_rd;
   logic [1:0]       status;
   logic [CNT_W-1:0] cnt_q;
   logic             uf_evt;
   logic             err_evt;

   wwdt_regs #(.DATA_W(DATA_W), .KEY(KEY)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .status    (status),
      .mode_q    (mode_q),
      .locked    (locked),
      .mode_wr   (mode_wr),
      .restart   (restart),
      .stat_rd   (stat_rd),
      .rdata     (rsp_rdata)
   );

   wwdt_counter #(.CNT_W(CNT_W), .N_HALT(N_HALT)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .run_en   (!mode_q.dis),
      .halt_req ({debug_halt, idle_halt}),
      .halt_en  ({mode_q.dbg_en, mode_q.idle_en}),
      .reload   (mode_q.reload[CNT_W-1:0]),
      .window   (mode_q.window[CNT_W-1:0]),
      .load     (mode_wr),
      .load_val (req_wdata[CNT_W-1:0]),
      .restart  (restart),
      .cnt_q    (cnt_q),
      .uf_evt   (uf_evt),
      .err_evt  (err_evt)
   );

   wwdt_fault u_fault (
      .clk       (clk),
      .rst_n     (rst_n),
      .uf_evt    (uf_evt),
      .err_evt   (err_evt),
      .stat_rd   (stat_rd),
      .irq_en    (mode_q.irq_en),
      .rst_en    (mode_q.rst_en),
      .proc_only (mode_q.proc_only),
      .status    (status),
      .irq       (fault_irq),
      .rst_pulse (rst_req),
      .rst_proc  (rst_proc_only)
   );

endmodule

// File: rtl/wwdt_chk.sv
module wwdt_chk
   import wwdt_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             idle_halt,
   input mode_t            mode_q,
   input logic             locked,
   input logic             stat_rd,
   input logic             uf_evt,
   input logic             err_evt,
   input logic [1:0]       status,
   input logic [CNT_W-1:0] cnt_q,
   input logic             fault_irq,
   input logic             rst_req,
   input logic             rst_proc_only
);

   // R3
   mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(mode_q));

   // R7
   stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !uf_evt && !err_evt) |=> (status == 2'b00));

   // R8
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_irq && !stat_rd) |=> fault_irq);

   // R9
   proc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_proc_only |-> rst_req);

   // R10
   dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q.dis && $past(mode_q.dis)) |-> (!rst_req && !fault_irq));

   // R11
   idle_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_halt && mode_q.idle_en && !req_valid) |=> $stable(cnt_q));

endmodule

bind wwdt_top wwdt_chk #(.CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .idle_halt     (idle_halt),
   .mode_q        (mode_q),
   .locked        (locked),
   .stat_rd       (stat_rd),
   .uf_evt        (uf_evt),
   .err_evt       (err_evt),
   .status        (status),
   .cnt_q         (cnt_q),
   .fault_irq     (fault_irq),
   .rst_req       (rst_req),
   .rst_proc_only (rst_proc_only)
);

// File: tb/wwdt_top_tb.sv
module wwdt_top_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        idle_halt = 1'b0;
   logic        debug_halt = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rsp_rdata;
   logic        fault_irq;
   logic        rst_req;
   logic        rst_proc_only;

   int n_chk = 0;
   int n_err = 0;
   int rst_cnt = 0;
   int proc_cnt = 0;
   bit done = 1'b0;

   localparam logic [31:0] GO  = 32'hA500_0001;
   localparam logic [31:0] M_B = (32'd1 << 29) | (32'd1 << 28) | (32'd10 << 16)
                               | (32'd1 << 13) | (32'd1 << 12) | 32'd20;

   always #4 clk = ~clk;

   wwdt_top u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick          (tick),
      .idle_halt     (idle_halt),
      .debug_halt    (debug_halt),
      .req_valid     (req_valid),
      .req_write     (req_write),
      .req_addr      (req_addr),
      .req_wdata     (req_wdata),
      .rsp_rdata     (rsp_rdata),
      .fault_irq     (fault_irq),
      .rst_req       (rst_req),
      .rst_proc_only (rst_proc_only)
   );

   always @(posedge clk) begin
      if (rst_req)       rst_cnt  <= rst_cnt + 1;
      if (rst_proc_only) proc_cnt <= proc_cnt + 1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      #1 d = rsp_rdata;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int b, p;

      // Phase A: reset configuration
      do_reset();
      rd(1, v);  chk("R1 mode reset value", v, 32'h3FFF_2FFF);
      rd(2, v);  chk("R1 status reset", v, 0);
      chk("R1 outputs low", {fault_irq, rst_req, rst_proc_only}, 0);
      b = rst_cnt; p = proc_cnt;
      ticks(4095);
      rd(2, v);  chk("R2 no underflow before 4096th tick", v, 0);
      ticks(1);
      chk("R8 no irq with enable clear", fault_irq, 0);
      rd(2, v);  chk("R2 underflow on 4096th tick", v, 1);
      chk("R9 reset pulse count", rst_cnt - b, 1);
      chk("R9 no proc-only flag", proc_cnt - p, 0);
      rd(2, v);  chk("R7 status cleared by read", v, 0);

      // Phase B: windowed operation
      do_reset();
      wr(1, M_B);
      rd(1, v);  chk("R3 first mode write taken", v, M_B);
      wr(1, 32'h0);
      rd(1, v);  chk("R3 second mode write ignored", v, M_B);
      for (int k = 0; k <= 20; k++) begin
         logic e;
         e = (k < 10);
         b = rst_cnt;
         ticks(k);
         wr(0, GO);
         chk("R8 irq follows fault", fault_irq, e);
         rd(2, v);  chk(e ? "R5 early restart error" : "R4 legal restart", v, e ? 2 : 0);
         chk("R9 pulse per fault", rst_cnt - b, e);
         chk("R8 irq cleared by status read", fault_irq, 0);
         if (e) begin
            ticks(10 - k);
            wr(0, GO);
            rd(2, v);  chk("R5 counter kept counting after error", v, 0);
         end
      end
      ticks(12);
      wr(0, 32'h5A00_0001);
      wr(0, 32'hA500_0000);
      ticks(8);
      rd(2, v);  chk("R6 bad commands did not reload", v, 0);
      ticks(1);
      chk("R8 irq on underflow", fault_irq, 1);
      rd(2, v);  chk("R2 underflow after reload value", v, 1);
      wr(0, 32'h5A00_0001);
      rd(2, v);  chk("R6 bad key above window no error", v, 0);
      idle_halt = 1'b1;
      ticks(25);
      idle_halt = 1'b0;
      rd(2, v);  chk("R11 idle halt pauses", v, 0);
      ticks(20);
      rd(2, v);  chk("R11 count resumes after idle", v, 0);
      ticks(1);
      rd(2, v);  chk("R11 underflow after idle resume", v, 1);
      debug_halt = 1'b1;
      ticks(25);
      debug_halt = 1'b0;
      ticks(20);
      rd(2, v);  chk("R11 debug halt pauses", v, 0);
      ticks(1);
      rd(2, v);  chk("R2 underflow reloads to 20", v, 1);
      ticks(9);
      wr(0, GO);
      rd(2, v);  chk("R5 one above window", v, 2);
      ticks(1);
      wr(0, GO);
      rd(2, v);  chk("R4 restart at window edge", v, 0);

      // Phase C: disabled
      do_reset();
      b = rst_cnt;
      wr(1, (32'd1 << 15) | M_B);
      ticks(30);
      wr(0, GO);
      rd(2, v);  chk("R10 no fault while disabled", v, 0);
      chk("R10 irq low while disabled", fault_irq, 0);
      wr(1, M_B);
      ticks(30);
      rd(2, v);  chk("R10 disable cannot be undone", v, 0);
      rd(1, v);  chk("R3 mode still disabled", v, (32'd1 << 15) | M_B);
      chk("R10 no reset request", rst_cnt - b, 0);

      // Phase D: processor-only reset, halt enables clear
      do_reset();
      b = rst_cnt; p = proc_cnt;
      wr(1, (32'd5 << 16) | (32'd1 << 14) | (32'd1 << 13) | 32'd5);
      idle_halt = 1'b1; debug_halt = 1'b1;
      ticks(5);
      rd(2, v);  chk("R11 disabled halts ignored", v, 0);
      ticks(1);
      chk("R8 irq stays low", fault_irq, 0);
      rd(2, v);  chk("R2 underflow with halts ignored", v, 1);
      chk("R9 reset pulse", rst_cnt - b, 1);
      chk("R9 proc-only flag", proc_cnt - p, 1);
      idle_halt = 1'b0; debug_halt = 1'b0;
      wr(0, GO);
      rd(2, v);  chk("R4 restart at reload equal to window", v, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule